// File: doc/BRIEF.md
# Paired Integer-Float Quantize Unit

This block moves packed graphics data between compact integer form and IEEE single-precision floating point, two operands at a time. Every operation carries its own configuration word. That word holds an element type and a signed power-of-two scale. The operation also has a direction. In the load direction each lane's 8-bit or 16-bit integer, signed or unsigned, becomes a float equal to the integer times 2^-scale. In the store direction each lane's float is multiplied by 2^scale, truncated toward zero and clamped into the integer type's range.

The load conversion has four steps:
- The integer is split into a sign and a magnitude.
- The magnitude is normalised with a leading-zero count and a left shift, which gives the exponent (biased by 127) and the fraction.
- The scale is subtracted from the exponent.
- Exponent overflow and underflow are clamped.

Both lanes share the configuration. The unit is a fixed two-stage pipeline with a valid qualifier and accepts one operation per cycle.

Top module: `qnt_unit`

## Requirements
- R1: After reset, valid_o and data_o are 0. valid_o is 1 exactly two cycles after each cycle with valid_i = 1 and is 0 otherwise. Back-to-back operations are accepted every cycle.
- R2: In any cycle where valid_o is 0, data_o keeps its previous value.
- R3: With dir_i = 0 (load), the type codes are 4 = u8 and 6 = s8, both taken from lane bits [7:0], and 5 = u16 and 7 = s16, both taken from lane bits [15:0]. For these types the lane result is the exact single-precision value of integer × 2^-scale. The scale is cfg_scale_i read as a 6-bit two's-complement number.
- R4: On load, an integer of zero gives 0x00000000 for every integer type.
- R5: With dir_i = 1 (store) and an integer type, the result is float × 2^scale truncated toward zero. Zero and denormal inputs give 0, and so does any magnitude below 1 after scaling.
- R6: On store, results saturate to the type's range: u8 0..255, u16 0..65535, s8 -128..127, s16 -32768..32767. Negative inputs to an unsigned type give 0.
- R7: On store, a NaN gives 0. +Inf gives the type's maximum and -Inf gives its minimum.
- R8: A store result fills the whole 32-bit lane. It is sign-extended for s8 and s16 and zero-extended for u8 and u16.
- R9: Type 0 (float) and the unused codes 1 to 3 copy each 32-bit lane to the output unchanged, in both directions.
- R10: Lane 0 is data bits [31:0] and lane 1 is bits [63:32]. The two lanes convert independently under the same configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| dir_i | input | 1 | 0 = load (integer to float), 1 = store (float to integer) |
| cfg_type_i | input | 3 | Element type code |
| cfg_scale_i | input | 6 | Power-of-two scale, two's complement |
| data_i | input | 64 | Two 32-bit input lanes |
| valid_o | output | 1 | Result present this cycle |
| data_o | output | 64 | Two 32-bit result lanes |

## Verification
The saturation and truncation edges of the store path are hard to reach. A float only lands exactly on a type limit, or just inside or outside it, for a narrow pairing of exponent and scale. Uniformly random 32-bit floats almost never hit that pairing. The random stimulus therefore draws exponents within about twenty of the bias and pairs them with random scales, so that results fall around the 8-bit and 16-bit limits. Directed vectors pin the exact values: -128.0, -129.0, 255.9, -0.5, NaN, both infinities, -0 and denormals, and, on the load side, the most negative integers and both extremes of the scale.

// File: rtl/qnt_pkg.sv
package qnt_pkg;
  localparam int unsigned FP_W = 32;

  typedef enum logic [2:0] {
    QT_F32 = 3'd0,
    QT_U8  = 3'd4,
    QT_U16 = 3'd5,
    QT_S8  = 3'd6,
    QT_S16 = 3'd7
  } qnt_type_e;

  function automatic logic is_int_type(logic [2:0] t);
    return t[2];
  endfunction
endpackage

// File: rtl/qnt_lzc.sv
module qnt_lzc #(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  // highest set bit wins; all-zero gives W
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/qnt_deq_lane.sv
module qnt_deq_lane
  import qnt_pkg::*;
#(
  parameter int unsigned SCALE_W = 6
) (
  input  logic [2:0]         typ_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [FP_W-1:0]    lane_i,
  output logic [FP_W-1:0]    res_o
);
  localparam int unsigned MW = 16;
  localparam int unsigned CW = $clog2(MW + 1);

  logic          sgn;
  logic [MW-1:0] mag;
  logic [MW-1:0] s8_ext;
  logic [CW-1:0] lz;
  logic [MW-1:0] norm;
  logic signed [15:0] scl_ext;
  logic signed [15:0] exp_v;

  assign s8_ext = {{8{lane_i[7]}}, lane_i[7:0]};

  // step 1: sign-magnitude
  always_comb begin
    sgn = 1'b0;
    mag = '0;
    unique case (typ_i)
      QT_U8:   mag = {8'h00, lane_i[7:0]};
      QT_U16:  mag = lane_i[15:0];
      QT_S8: begin
        sgn = lane_i[7];
        mag = sgn ? (~s8_ext + 16'd1) : s8_ext;
      end
      QT_S16: begin
        sgn = lane_i[15];
        mag = sgn ? (~lane_i[15:0] + 16'd1) : lane_i[15:0];
      end
      default: mag = '0;
    endcase
  end

  // step 2: normalise
  qnt_lzc #(.W(MW)) u_lzc (.vec_i(mag), .cnt_o(lz));
  assign norm = mag << lz;

  // step 3: exponent minus scale
  assign scl_ext = {{(16-SCALE_W){scale_i[SCALE_W-1]}}, scale_i};
  assign exp_v   = 16'sd127 + 16'sd15 - $signed({{(16-CW){1'b0}}, lz}) - scl_ext;

  // step 4: clamp (reachable only with a wider scale field)
  always_comb begin
    if (!is_int_type(typ_i))     res_o = lane_i;
    else if (!norm[MW-1])        res_o = '0;
    else if (exp_v <= 16'sd0)    res_o = '0;
    else if (exp_v >= 16'sd255)  res_o = {sgn, 8'hff, 23'd0};
    else                         res_o = {sgn, exp_v[7:0], norm[MW-2:0], 8'd0};
  end
endmodule

// File: rtl/qnt_q_lane.sv
module qnt_q_lane
  import qnt_pkg::*;
#(
  parameter int unsigned SCALE_W = 6
) (
  input  logic [2:0]         typ_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [FP_W-1:0]    lane_i,
  output logic [FP_W-1:0]    res_o
);
  logic        sgn;
  logic [7:0]  e;
  logic [22:0] m;
  logic signed [15:0] scl_ext;
  logic signed [15:0] ee;
  logic        is_nan, is_inf, big;
  logic [4:0]  sh;
  logic [23:0] shv;
  logic [23:0] mag;
  logic [23:0] pos_lim, neg_lim, r_mag;

  assign sgn = lane_i[31];
  assign e   = lane_i[30:23];
  assign m   = lane_i[22:0];

  assign scl_ext = {{(16-SCALE_W){scale_i[SCALE_W-1]}}, scale_i};
  assign ee      = $signed({8'd0, e}) - 16'sd127 + scl_ext;

  assign is_nan = (e == 8'hff) && (m != '0);
  assign is_inf = (e == 8'hff) && (m == '0);
  assign big    = is_inf || (ee >= 16'sd16);
  assign sh     = 5'd23 - ee[4:0];
  assign shv    = {1'b1, m} >> sh;

  // truncated magnitude; big values exceed every limit
  always_comb begin
    if (big)                              mag = 24'h010000;
    else if (e == 8'd0 || ee < 16'sd0)    mag = '0;
    else                                  mag = shv;
  end

  always_comb begin
    unique case (typ_i)
      QT_U8:   begin pos_lim = 24'd255;   neg_lim = 24'd0;     end
      QT_U16:  begin pos_lim = 24'd65535; neg_lim = 24'd0;     end
      QT_S8:   begin pos_lim = 24'd127;   neg_lim = 24'd128;   end
      QT_S16:  begin pos_lim = 24'd32767; neg_lim = 24'd32768; end
      default: begin pos_lim = 24'd0;     neg_lim = 24'd0;     end
    endcase
  end

  always_comb begin
    if (sgn) r_mag = (mag > neg_lim) ? neg_lim : mag;
    else     r_mag = (mag > pos_lim) ? pos_lim : mag;
  end

  always_comb begin
    if (!is_int_type(typ_i)) res_o = lane_i;
    else if (is_nan)         res_o = '0;
    else if (sgn)            res_o = ~{8'd0, r_mag} + 32'd1;
    else                     res_o = {8'd0, r_mag};
  end
endmodule

// File: rtl/qnt_unit.sv
module qnt_unit
  import qnt_pkg::*;
#(
  parameter int unsigned LANES   = 2,
  parameter int unsigned SCALE_W = 6,
  localparam int unsigned DATA_W = LANES * FP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               dir_i,
  input  logic [2:0]         cfg_type_i,
  input  logic [SCALE_W-1:0] cfg_scale_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               valid_o,
  output logic [DATA_W-1:0]  data_o
);
  logic               v_q1, dir_q1;
  logic [2:0]         typ_q1;
  logic [SCALE_W-1:0] scl_q1;
  logic [DATA_W-1:0]  dat_q1;
  logic [DATA_W-1:0]  res;

  // stage 1: capture operands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q1   <= 1'b0;
      dir_q1 <= 1'b0;
      typ_q1 <= '0;
      scl_q1 <= '0;
      dat_q1 <= '0;
    end else begin
      v_q1 <= valid_i;
      if (valid_i) begin
        dir_q1 <= dir_i;
        typ_q1 <= cfg_type_i;
        scl_q1 <= cfg_scale_i;
        dat_q1 <= data_i;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [FP_W-1:0] lane, d_res, q_res, l_res;
    assign lane = dat_q1[g*FP_W +: FP_W];

    qnt_deq_lane #(.SCALE_W(SCALE_W)) u_deq (
      .typ_i(typ_q1), .scale_i(scl_q1), .lane_i(lane), .res_o(d_res)
    );
    qnt_q_lane #(.SCALE_W(SCALE_W)) u_q (
      .typ_i(typ_q1), .scale_i(scl_q1), .lane_i(lane), .res_o(q_res)
    );

    assign l_res = dir_q1 ? q_res : d_res;
    assign res[g*FP_W +: FP_W] = l_res;

    a_r4_zero_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_q1 && !dir_q1 && is_int_type(typ_q1) &&
      (typ_q1[0] ? (lane[15:0] == '0) : (lane[7:0] == '0)) |-> d_res == '0);

    a_r6_u8_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_q1 && dir_q1 && typ_q1 == QT_U8 |-> l_res[31:8] == '0);

    a_r7_nan_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_q1 && dir_q1 && is_int_type(typ_q1) && lane[30:23] == 8'hff &&
      lane[22:0] != '0 |-> l_res == '0);

    a_r8_s8_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_q1 && dir_q1 && typ_q1 == QT_S8 |->
      (l_res[31:7] == '0 || l_res[31:7] == '1));

    a_r9_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_q1 && !is_int_type(typ_q1) |-> l_res == lane);
  end

  // stage 2: result register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= v_q1;
      if (v_q1) data_o <= res;
    end
  end

  a_r1_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q1 |=> valid_o);
  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_q1 |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_q1 |=> $stable(data_o));
endmodule

// File: tb/sim_qnt_unit.sv
`timescale 1ns/1ps
module sim_qnt_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        dir_i = 1'b0;
  logic [2:0]  cfg_type_i = '0;
  logic [5:0]  cfg_scale_i = '0;
  logic [63:0] data_i = '0;
  logic        valid_o;
  logic [63:0] data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  qnt_unit u0 (.*);

  // ---- reference model ----
  function automatic logic [31:0] ref_load(logic [2:0] t, logic [5:0] sc, logic [31:0] x);
    longint v, a, mant;
    int p, sci, ex;
    bit s;
    case (t)
      3'd4: v = longint'(x[7:0]);
      3'd5: v = longint'(x[15:0]);
      3'd6: v = longint'($signed(x[7:0]));
      3'd7: v = longint'($signed(x[15:0]));
      default: return x;
    endcase
    if (v == 0) return 32'd0;
    s = (v < 0);
    a = s ? -v : v;
    p = 0;
    for (int i = 0; i < 17; i++) if (a >= (64'sd1 <<< i)) p = i;
    sci = int'($signed(sc));
    ex = 127 + p - sci;
    mant = (a << (23 - p)) & 64'h7fffff;
    return {s, ex[7:0], mant[22:0]};
  endfunction

  function automatic logic [31:0] ref_store(logic [2:0] t, logic [5:0] sc, logic [31:0] f);
    longint mag, pl, nl, r;
    int ee;
    bit s;
    case (t)
      3'd4: begin pl = 255;   nl = 0;     end
      3'd5: begin pl = 65535; nl = 0;     end
      3'd6: begin pl = 127;   nl = 128;   end
      3'd7: begin pl = 32767; nl = 32768; end
      default: return f;
    endcase
    s = f[31];
    if (f[30:23] == 8'hff && f[22:0] != 0) return 32'd0;
    if (f[30:23] == 8'hff) mag = 64'd1 << 40;
    else if (f[30:23] == 0) mag = 0;
    else begin
      ee = int'(f[30:23]) - 127 + int'($signed(sc));
      if (ee < 0) mag = 0;
      else if (ee > 30) mag = 64'd1 << 40;
      else mag = (longint'({1'b1, f[22:0]}) << ee) >> 23;
    end
    if (s) begin r = (mag > nl) ? nl : mag; r = -r; end
    else   r = (mag > pl) ? pl : mag;
    return r[31:0];
  endfunction

  // ---- pipeline scoreboard: slot 1 = last cycle, slot 2 = two cycles ago ----
  bit          s1_v = 0, s2_v = 0;
  logic [63:0] s1_d = '0, s2_d = '0, last_d = '0;
  string       s1_t = "R1", s2_t = "R1";

  task automatic step(input bit v, input bit dr, input logic [2:0] t,
                      input logic [5:0] sc, input logic [63:0] d, input string tag);
    @(negedge clk_i);
    n_chk++;
    if (valid_o !== s2_v) begin
      n_bad++;
      $display("FAIL R1 valid_o act=%0b exp=%0b", valid_o, s2_v);
    end
    if (s2_v) begin
      n_chk++;
      if (data_o !== s2_d) begin
        n_bad++;
        $display("FAIL %s data_o act=%h exp=%h", s2_t, data_o, s2_d);
      end
      last_d = s2_d;
    end else begin
      n_chk++;
      if (data_o !== last_d) begin
        n_bad++;
        $display("FAIL R2 hold data_o act=%h exp=%h", data_o, last_d);
      end
    end
    s2_v = s1_v; s2_d = s1_d; s2_t = s1_t;
    valid_i = v; dir_i = dr; cfg_type_i = t; cfg_scale_i = sc; data_i = d;
    s1_v = v; s1_t = tag;
    if (v) begin
      if (dr) s1_d = {ref_store(t, sc, d[63:32]), ref_store(t, sc, d[31:0])};
      else    s1_d = {ref_load(t, sc, d[63:32]),  ref_load(t, sc, d[31:0])};
    end
  endtask

  function automatic logic [31:0] rnd_float();
    logic [7:0] ex;
    if ($urandom_range(0, 7) == 0) return $urandom();
    ex = 8'(127 + $urandom_range(0, 40) - 20);
    return {1'($urandom_range(0, 1)), ex, 23'($urandom())};
  endfunction

  function automatic logic [2:0] rnd_type();
    int k = $urandom_range(0, 9);
    if (k < 2) return 3'($urandom_range(0, 3));
    return 3'(4 + (k % 4));
  endfunction

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    n_chk++;
    if (valid_o !== 1'b0 || data_o !== 64'd0) begin
      n_bad++;
      $display("FAIL R1 reset act=%b/%h exp=0/0", valid_o, data_o);
    end
    rst_ni = 1'b1;

    // R3 load corners: extremes of the integer range and of the scale
    step(1, 0, 3'd6, 6'd0,  {32'h0000_0080, 32'h0000_007f}, "R3");
    step(1, 0, 3'd7, 6'd0,  {32'h0000_8000, 32'h0000_ffff}, "R3");
    step(1, 0, 3'd5, 6'h20, {32'h0000_ffff, 32'h0000_0001}, "R3");
    step(1, 0, 3'd4, 6'h1f, {32'h0000_00ff, 32'h0000_0003}, "R3");
    // R4: zero integers, upper lane bits set
    step(1, 0, 3'd6, 6'd5,  {32'hffff_ff00, 32'h1234_0000}, "R4");
    step(1, 0, 3'd7, 6'h3b, {32'hab00_0000, 32'h0000_0000}, "R4");
    // R2: idle gap must hold the output
    step(0, 0, 3'd0, 6'd0, 64'hdead_beef_dead_beef, "R2");
    step(0, 1, 3'd4, 6'd0, 64'h1111_2222_3333_4444, "R2");
    step(0, 0, 3'd0, 6'd0, 64'd0, "R2");
    // R5: truncation toward zero; -0.5, 1.75, denormal, -0
    step(1, 1, 3'd6, 6'd0,  {32'hbf00_0000, 32'h3fe0_0000}, "R5");
    step(1, 1, 3'd7, 6'd0,  {32'h0000_0001, 32'h8000_0000}, "R5");
    step(1, 1, 3'd5, 6'd4,  {32'h3fc0_0000, 32'hc0a0_0000}, "R5");
    // R6: saturation; -128.0 fits s8, -129.0 clamps, 255.9 u8, -3 u16
    step(1, 1, 3'd6, 6'd0,  {32'hc300_0000, 32'hc301_0000}, "R6");
    step(1, 1, 3'd4, 6'd0,  {32'h437f_e666, 32'h4380_0000}, "R6");
    step(1, 1, 3'd5, 6'd0,  {32'hc040_0000, 32'h4780_0000}, "R6");
    step(1, 1, 3'd7, 6'h3f, {32'h4780_0000, 32'hc780_0002}, "R6");
    // R7: NaN and infinities
    step(1, 1, 3'd7, 6'd0,  {32'h7fc0_0000, 32'hff80_0000}, "R7");
    step(1, 1, 3'd4, 6'd3,  {32'h7f80_0000, 32'hffff_ffff}, "R7");
    // R8: extension of negative store results
    step(1, 1, 3'd6, 6'd0,  {32'hc0a0_0000, 32'hbf80_0000}, "R8");
    step(1, 1, 3'd5, 6'd0,  {32'h477f_ff00, 32'h4300_0000}, "R8");
    // R9: passthrough codes, both directions
    step(1, 0, 3'd0, 6'd7,  64'h7fc0_0001_8000_00ff, "R9");
    step(1, 1, 3'd2, 6'd9,  64'h0123_4567_89ab_cdef, "R9");
    step(1, 1, 3'd0, 6'd1,  64'hff80_0000_7fc0_0000, "R9");
    // R10: lanes differ in class under one config
    step(1, 1, 3'd4, 6'd0,  {32'h4396_0000, 32'h7fc0_0000}, "R10");
    step(1, 0, 3'd7, 6'd2,  {32'h0000_0000, 32'h0000_8001}, "R10");

    // R1 back-to-back random stream with occasional gaps
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom_range(0, 5) != 0);
      bit dr = 1'($urandom_range(0, 1));
      logic [2:0] t = rnd_type();
      logic [5:0] sc = 6'($urandom());
      logic [63:0] d;
      if (dr) d = {rnd_float(), rnd_float()};
      else    d = {32'($urandom()), 32'($urandom())};
      step(v, dr, t, sc, d, dr ? "R5/R6" : "R3");
    end
    repeat (3) step(0, 0, 3'd0, 6'd0, 64'd0, "R2");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule